// File: doc/BRIEF.md
# Two-Wire Bus Input Glitch Filter

This block cleans up the clock and data inputs of a two-wire serial bus before any protocol logic samples them. Each raw line goes through a two-flop synchronizer into the peripheral clock domain. It then goes through a stability filter that accepts a new level only after that level has been present for a programmable number of consecutive clocks. Shorter excursions are discarded.

A 4-bit selector N sets the acceptance width to 3+N clocks, so the width ranges from 3 to 18 clocks. The block watches the two filtered lines and produces single-cycle pulses for START and STOP conditions. It also keeps a bus-busy flag that a START sets and a STOP clears. The protocol engine consumes the filtered levels, the event pulses and the busy flag directly.

Top module: `tw_line_conditioner`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both filtered outputs are 1, busy is 0, and neither event pulse is asserted.
- R2: A raw excursion held for fewer than 3+N rising clock edges never appears on the filtered output of that line. N is the unsigned value of `nf_sel`.
- R3: A raw level held for at least 3+N edges appears on the filtered output at the (N+5)-th rising edge. The first rising edge that samples the new raw level counts as edge 1.
- R4: The stability count restarts whenever the synchronized level matches the filtered level again. Two excursions of 2+N edges each, separated by one edge of the old level, do not accumulate and are both discarded.
- R5: `start_o` is high for exactly one cycle when filtered SDA goes from 1 to 0 while filtered SCL is 1 in both that cycle and the previous one. It is asserted in the first cycle in which filtered SDA reads 0.
- R6: `stop_o` is high for exactly one cycle when filtered SDA goes from 0 to 1 while filtered SCL is 1 in both that cycle and the previous one. It is asserted in the first cycle in which filtered SDA reads 1.
- R7: `busy_o` becomes 1 in the cycle after a START pulse and returns to 0 in the cycle after a STOP pulse. At no other time does it change.
- R8: Every value of N from 0 to 15 gives the acceptance width 3+N, covering 3 to 18 clocks.
- R9: SDA transitions while filtered SCL is 0 produce neither pulse and leave `busy_o` unchanged. SCL transitions while SDA is steady produce no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw clock line from the pad |
| sda_in | input | 1 | Raw data line from the pad |
| nf_sel | input | 4 | Filter selector N; acceptance width is 3+N clocks |
| scl_o | output | 1 | Filtered clock line |
| sda_o | output | 1 | Filtered data line |
| start_o | output | 1 | One-cycle START event |
| stop_o | output | 1 | One-cycle STOP event |
| busy_o | output | 1 | Bus busy, set by START, cleared by STOP |

## Verification
The bench sweeps all sixteen filter settings and drives each line with excursions one edge shorter than, equal to, and one edge longer than the width. A filter with an off-by-one in its compare would pass the short pulse or drop the exact-width one, and a wrong latency shows up as the output edge landing in the wrong cycle. Two near-width pulses split by a single-cycle gap catch a counter that pauses instead of restarting. SDA is also toggled with SCL held low, which catches an event detector that ignores the clock level and would set busy spuriously.

// File: rtl/tw_cond_pkg.sv
package tw_cond_pkg;

    // Number of conditioned lines and their lane positions
    localparam int LINES      = 2;
    localparam int SCL_LANE   = 0;
    localparam int SDA_LANE   = 1;

    // Defaults for the filter configuration
    localparam int NSEL_W_DEF = 4;
    localparam int BASE_W_DEF = 3;
    localparam int SYNC_DEF   = 2;

    // Filtered pair of bus levels
    typedef struct packed {
        logic sda;
        logic scl;
    } line_pair_t;

    // Events derived from the filtered pair
    typedef struct packed {
        logic stop;
        logic start;
    } bus_evt_t;

    // Width of a counter able to hold base + 2**nsel_w - 1
    function automatic int cnt_bits(input int base_w, input int nsel_w);
        return $clog2(base_w + (1 << nsel_w));
    endfunction

endpackage

// File: rtl/tw_sync2.sv
module tw_sync2 #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RESET_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/tw_stab_filter.sv
module tw_stab_filter #(
    parameter int   CNT_W     = 5,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic [CNT_W-1:0] limit_m1,
    output logic             q
);
    logic [CNT_W-1:0] run_len;
    logic             level;
    logic             differs;
    logic             reached;

    assign differs = (din != level);
    assign reached = (run_len == limit_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            level   <= RESET_VAL;
            run_len <= '0;
        end else if (!differs) begin
            run_len <= '0;
        end else if (reached) begin
            level   <= din;
            run_len <= '0;
        end else begin
            run_len <= run_len + 1'b1;
        end
    end

    assign q = level;

endmodule

// File: rtl/tw_bus_event.sv
module tw_bus_event
    import tw_cond_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  line_pair_t lines,
    output bus_evt_t   evt,
    output logic       busy
);
    line_pair_t prev;
    logic       scl_held;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '{sda: 1'b1, scl: 1'b1};
        end else begin
            prev <= lines;
        end
    end

    assign scl_held  = prev.scl & lines.scl;
    assign evt.start = scl_held & prev.sda & ~lines.sda;
    assign evt.stop  = scl_held & ~prev.sda & lines.sda;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
        end else if (evt.start) begin
            busy <= 1'b1;
        end else if (evt.stop) begin
            busy <= 1'b0;
        end
    end

endmodule

// File: rtl/tw_line_conditioner.sv
module tw_line_conditioner
    import tw_cond_pkg::*;
#(
    parameter int NSEL_W      = NSEL_W_DEF,
    parameter int BASE_WIDTH  = BASE_W_DEF,
    parameter int SYNC_STAGES = SYNC_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [NSEL_W-1:0] nf_sel,
    output logic              scl_o,
    output logic              sda_o,
    output logic              start_o,
    output logic              stop_o,
    output logic              busy_o
);
    localparam int CNT_W = cnt_bits(BASE_WIDTH, NSEL_W);

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] filt;
    logic [CNT_W-1:0] limit_m1;
    line_pair_t       pair;
    bus_evt_t         evt;

    assign raw[SCL_LANE] = scl_in;
    assign raw[SDA_LANE] = sda_in;

    // Accept after BASE_WIDTH + N consecutive differing samples
    assign limit_m1 = CNT_W'(BASE_WIDTH - 1) + CNT_W'(nf_sel);

    for (genvar g = 0; g < LINES; g++) begin : g_lane
        tw_sync2 #(
            .STAGES    (SYNC_STAGES),
            .RESET_VAL (1'b1)
        ) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw[g]),
            .q   (synced[g])
        );

        tw_stab_filter #(
            .CNT_W     (CNT_W),
            .RESET_VAL (1'b1)
        ) u_filt (
            .clk      (clk),
            .rst      (rst),
            .din      (synced[g]),
            .limit_m1 (limit_m1),
            .q        (filt[g])
        );
    end

    assign pair.scl = filt[SCL_LANE];
    assign pair.sda = filt[SDA_LANE];

    tw_bus_event u_evt (
        .clk   (clk),
        .rst   (rst),
        .lines (pair),
        .evt   (evt),
        .busy  (busy_o)
    );

    assign scl_o   = pair.scl;
    assign sda_o   = pair.sda;
    assign start_o = evt.start;
    assign stop_o  = evt.stop;

endmodule

// File: rtl/tw_line_conditioner_chk.sv
module tw_line_conditioner_chk (
    input logic clk,
    input logic rst,
    input logic scl_o,
    input logic sda_o,
    input logic start_o,
    input logic stop_o,
    input logic busy_o
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (scl_o && sda_o && !busy_o && !start_o && !stop_o));

    // R2
    scl_no_double_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(scl_o) |=> $stable(scl_o));

    // R2
    sda_no_double_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_o) |=> $stable(sda_o));

    // R5
    start_shape_chk: assert property (@(posedge clk) disable iff (rst)
        start_o |-> (scl_o && !sda_o && $past(scl_o) && $past(sda_o)));

    // R6
    stop_shape_chk: assert property (@(posedge clk) disable iff (rst)
        stop_o |-> (scl_o && sda_o && $past(scl_o) && !$past(sda_o)));

    // R5
    events_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_o, stop_o}));

    // R7
    busy_set_chk: assert property (@(posedge clk) disable iff (rst)
        start_o |=> busy_o);

    // R7
    busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
        stop_o |=> !busy_o);

    // R7
    busy_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_o));

    // R7
    busy_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> $past(stop_o));

endmodule

bind tw_line_conditioner tw_line_conditioner_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .scl_o   (scl_o),
    .sda_o   (sda_o),
    .start_o (start_o),
    .stop_o  (stop_o),
    .busy_o  (busy_o)
);

// File: tb/sim_tw_line_conditioner.sv
`timescale 1ns/1ps
module sim_tw_line_conditioner;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic [3:0] nf_sel = 4'd0;
    logic       scl_o, sda_o, start_o, stop_o, busy_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tw_line_conditioner u0 (
        .clk     (clk),
        .rst     (rst),
        .scl_in  (scl_in),
        .sda_in  (sda_in),
        .nf_sel  (nf_sel),
        .scl_o   (scl_o),
        .sda_o   (sda_o),
        .start_o (start_o),
        .stop_o  (stop_o),
        .busy_o  (busy_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s N=%0d actual=%0d expected=%0d", req, what, nf_sel, act, exp);
        end
    endtask

    task automatic set_line(input bit on_sda, input logic v);
        if (on_sda) sda_in = v;
        else        scl_in = v;
    endtask

    // Called just after a negedge. Drives up to two low excursions on one
    // line and records, by negedge index, when each output effect appears.
    task automatic run_pattern(input bit on_sda, input int p1, input int gap, input int p2,
                               input int w,
                               output int fl, output int fh, output int st, output int sp,
                               output int br, output int bf, output int nst, output int nsp);
        int  len;
        logic cur;
        logic pb;
        len = p1 + gap + p2 + w + 8;
        fl = 0; fh = 0; st = 0; sp = 0; br = 0; bf = 0; nst = 0; nsp = 0;
        pb = busy_o;
        set_line(on_sda, 1'b0);
        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            cur = on_sda ? sda_o : scl_o;
            if (fl == 0 && cur == 1'b0) fl = i;
            else if (fl != 0 && fh == 0 && cur == 1'b1) fh = i;
            if (start_o) begin nst++; if (st == 0) st = i; end
            if (stop_o)  begin nsp++; if (sp == 0) sp = i; end
            if (busy_o && !pb && br == 0) br = i;
            if (!busy_o && pb && bf == 0) bf = i;
            pb = busy_o;
            if (i == p1) set_line(on_sda, 1'b1);
            if (p2 > 0 && i == p1 + gap) set_line(on_sda, 1'b0);
            if (p2 > 0 && i == p1 + gap + p2) set_line(on_sda, 1'b1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int fl, fh, st, sp, br, bf, nst, nsp, w;
        repeat (4) @(negedge clk);
        // R1: outputs during reset
        chk("R1", "scl in reset", scl_o, 1);
        chk("R1", "busy in reset", busy_o, 0);
        rst = 1'b0;
        @(negedge clk);
        // R1: first cycle after reset
        chk("R1", "scl after reset", scl_o, 1);
        chk("R1", "sda after reset", sda_o, 1);
        chk("R1", "busy after reset", busy_o, 0);
        chk("R1", "start after reset", start_o, 0);
        chk("R1", "stop after reset", stop_o, 0);

        for (int n = 0; n < 16; n++) begin
            nf_sel = 4'(n);
            w = 3 + n;
            repeat (4) @(negedge clk);

            // R2: SCL excursion one edge short
            run_pattern(1'b0, w - 1, 0, 0, w, fl, fh, st, sp, br, bf, nst, nsp);
            chk("R2", "scl short pulse seen", fl, 0);
            chk("R9", "scl short pulse events", nst + nsp, 0);

            // R3 R8: SCL excursion exactly the width
            run_pattern(1'b0, w, 0, 0, w, fl, fh, st, sp, br, bf, nst, nsp);
            chk("R3", "scl fall index", fl, w + 2);
            chk("R8", "scl rise index", fh, 2 * w + 2);
            chk("R9", "scl pulse events", nst + nsp, 0);

            // R2: SDA excursion one edge short (SCL high)
            run_pattern(1'b1, w - 1, 0, 0, w, fl, fh, st, sp, br, bf, nst, nsp);
            chk("R2", "sda short pulse seen", fl, 0);
            chk("R7", "sda short pulse busy", br, 0);

            // R4: two short excursions with one-edge gap
            run_pattern(1'b0, w - 1, 1, w - 1, w, fl, fh, st, sp, br, bf, nst, nsp);
            chk("R4", "scl split pulse seen", fl, 0);
            run_pattern(1'b1, w - 1, 1, w - 1, w, fl, fh, st, sp, br, bf, nst, nsp);
            chk("R4", "sda split pulse events", nst + nsp, 0);

            // R5 R6 R7: accepted SDA excursions with SCL high
            for (int k = 0; k < 2; k++) begin
                int p;
                p = w + k;
                run_pattern(1'b1, p, 0, 0, w, fl, fh, st, sp, br, bf, nst, nsp);
                chk("R3", "sda fall index", fl, w + 2);
                chk("R5", "start index", st, w + 2);
                chk("R5", "start count", nst, 1);
                chk("R7", "busy rise index", br, w + 3);
                chk("R6", "stop index", sp, p + w + 2);
                chk("R6", "stop count", nsp, 1);
                chk("R7", "busy fall index", bf, p + w + 3);
            end

            // R9: SDA moves while SCL held low
            scl_in = 1'b0;
            repeat (w + 4) @(negedge clk);
            chk("R9", "scl held low", scl_o, 0);
            run_pattern(1'b1, w + 2, 0, 0, w, fl, fh, st, sp, br, bf, nst, nsp);
            chk("R9", "sda moved under low scl", fl, w + 2);
            chk("R9", "events under low scl", nst + nsp, 0);
            chk("R9", "busy under low scl", br, 0);
            scl_in = 1'b1;
            repeat (w + 4) @(negedge clk);
            chk("R9", "busy after scl release", busy_o, 0);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule